// File: doc/BRIEF.md
# Auto-Incrementing Work-RAM Access Port

This block gives a processor a narrow window onto a 128 KiB work RAM. The processor sees four byte registers behind one select line. One is a data register; the other three together set a 17-bit pointer into the RAM. Each access through the data register is forwarded to the RAM at the pointer's location. Once that access is complete, the pointer moves on by one, so a run of bytes can be streamed in or out without reloading the address.

The RAM address is built by ORing the pointer onto a fixed 24-bit base of 0x7E0000. Read and write cycles on the data register pass straight through to the RAM strobes in the same cycle. The pointer registers cannot be read back. A read from one of them returns the byte most recently carried on the processor data path.

Top module: `wram_port`

## Requirements
- R1: After a synchronous active-low reset, the pointer is 0, so `ram_addr` is 0x7E0000. No RAM strobe is active. The held open-bus byte is 0x00.
- R2: `ram_addr` always equals 0x7E0000 ORed with the 17-bit pointer, so bits 23:17 always read as the base value.
- R3: A write strobe with `cpu_reg` = 0 (data register) raises `ram_wr` with `ram_wdata` = `cpu_wdata` at the current pointer address. The pointer then advances by one.
- R4: A read strobe with `cpu_reg` = 0 raises `ram_rd` and returns `ram_rdata` on `cpu_rdata` from the current pointer address. The pointer then advances by one.
- R5: The increment wraps within 17 bits, so the access after one at pointer 0x1FFFF goes to pointer 0x00000. This holds for reads and for writes.
- R6: Writing `cpu_reg` = 1 replaces pointer bits 7:0, and `cpu_reg` = 2 replaces bits 15:8. Writing `cpu_reg` = 3 copies data bit 0 into pointer bit 16 and ignores data bits 7:1. Every pointer bit outside the chosen field keeps its value.
- R7: A strobe held over several cycles counts as one access. The pointer, and so `ram_addr`, stays fixed while the strobe is held, and advances exactly once on the clock edge after the strobe drops. Two accesses need at least one idle cycle between them.
- R8: A read with `cpu_reg` = 1, 2 or 3 raises no RAM strobe. It returns the open-bus byte: the last byte the processor wrote to any register of the block, or the last byte read through the data register, whichever came later.
- R9: RAM strobes are raised only while `cpu_sel` is high and `cpu_reg` = 0. If read and write are both asserted, the cycle is treated as a write. A data access with `cpu_sel` low leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_sel | input | 1 | Window select |
| cpu_reg | input | 2 | Register index: 0 data, 1 pointer low, 2 pointer middle, 3 pointer high |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data |
| ram_addr | output | 24 | RAM address (base ORed with pointer) |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |

## Verification
The only internal state is the pointer, the open-bus byte and one flag recording that an access was in progress. A wrong pointer shows on `ram_addr` at once, on the first cycle of the next data access. That makes a missed, doubled or misplaced increment visible one access later, at the address where the RAM strobe rises. A loss of the in-progress flag shows up as a skipped address after a held strobe. A stale open-bus byte appears on the very next read of a pointer register.

// File: rtl/wram_port_pkg.sv
// Shared definitions for the work-RAM access port.
// Assumes a 2-bit register index: one data register and up to three
// pointer lanes.
package wram_port_pkg;
    localparam int REG_W = 2;

    typedef enum logic [REG_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_PLO  = 2'd1,
        SEL_PMID = 2'd2,
        SEL_PHI  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/wram_ptr.sv
// Pointer register of the access port.
// Loads any byte lane from the processor data, and post-increments
// modulo 2^PTR_W.
// Assumes lane k covers bits [DW*k +: DW]. The top lane may be narrower
// than DW, in which case only its low data bits are taken.
module wram_ptr #(
    parameter int PTR_W  = 17,
    parameter int DW     = 8,
    parameter int NLANES = (PTR_W + DW - 1) / DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLANES-1:0] lane_ld,
    input  logic [DW-1:0]     ld_data,
    input  logic              step,
    output logic [PTR_W-1:0]  ptr
);
    logic [PTR_W-1:0] nxt;

    // Next pointer: increment first, then let any lane load override its bits.
    always_comb begin
        nxt = step ? ptr + PTR_W'(1) : ptr;
        for (int b = 0; b < PTR_W; b++) begin
            if (lane_ld[b / DW]) nxt[b] = ld_data[b % DW];
        end
    end

    // Pointer state with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= nxt;
    end
endmodule

// File: rtl/wram_acc_track.sv
// Access tracker of the access port.
// Turns a possibly multi-cycle data strobe into a single step pulse. The
// pulse is raised in the first cycle after the strobe drops.
// Assumes accesses are separated by at least one idle cycle.
module wram_acc_track (
    input  logic clk,
    input  logic rst_n,
    input  logic acc,
    output logic step
);
    logic acc_q;

    // Remember whether a data access was active in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= 1'b0;
        else        acc_q <= acc;
    end

    // Step once, when the access has just ended.
    always_comb step = acc_q && !acc;
endmodule

// File: rtl/wram_bus_mux.sv
// Read-data path of the access port.
// Holds the open-bus byte and selects between RAM data and that byte.
// Assumes processor writes take priority over data reads when the byte
// is captured.
module wram_bus_mux #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_wr,
    input  logic [DW-1:0] wdata,
    input  logic          cap_rd,
    input  logic [DW-1:0] ram_rdata,
    input  logic          show_ram,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] bus_q;

    // Capture the last byte carried on the processor data path.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_q <= '0;
        else if (cap_wr) bus_q <= wdata;
        else if (cap_rd) bus_q <= ram_rdata;
    end

    // The data register shows RAM data; the pointer registers show the held byte.
    always_comb rdata = show_ram ? ram_rdata : bus_q;
endmodule

// File: rtl/wram_port.sv
// Auto-incrementing work-RAM access port (top).
// Decodes the four processor registers, forwards data-register cycles to
// the RAM at BASE | pointer, and steps the pointer after each access.
// Assumes PTR_W is between 9 and 24, so that the lanes fit the 2-bit
// register index.
module wram_port
    import wram_port_pkg::*;
#(
    parameter int                PTR_W  = 17,
    parameter int                ADDR_W = 24,
    parameter int                DW     = 8,
    parameter logic [ADDR_W-1:0] BASE   = 24'h7E0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic [REG_W-1:0]  cpu_reg,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DW-1:0]     ram_wdata,
    input  logic [DW-1:0]     ram_rdata,
    output logic              ram_rd,
    output logic              ram_wr
);
    localparam int NLANES = (PTR_W + DW - 1) / DW;

    logic              hit_data, data_wr, data_rd, acc, step;
    logic [NLANES-1:0] lane_ld;
    logic [PTR_W-1:0]  ptr;

    // Decode data-register cycles; a write wins over a simultaneous read.
    always_comb begin
        hit_data = cpu_sel && (reg_sel_e'(cpu_reg) == SEL_DATA);
        data_wr  = hit_data && cpu_wr;
        data_rd  = hit_data && cpu_rd && !cpu_wr;
        acc      = data_wr || data_rd;
    end

    // One load enable per pointer lane; lane k sits at register index k+1.
    for (genvar k = 0; k < NLANES; k++) begin : g_lane
        assign lane_ld[k] = cpu_sel && cpu_wr && (cpu_reg == REG_W'(k + 1));
    end

    wram_acc_track u_trk (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .step  (step)
    );

    wram_ptr #(.PTR_W(PTR_W), .DW(DW), .NLANES(NLANES)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_ld (lane_ld),
        .ld_data (cpu_wdata),
        .step    (step),
        .ptr     (ptr)
    );

    wram_bus_mux #(.DW(DW)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_wr    (cpu_sel && cpu_wr),
        .wdata     (cpu_wdata),
        .cap_rd    (data_rd),
        .ram_rdata (ram_rdata),
        .show_ram  (hit_data),
        .rdata     (cpu_rdata)
    );

    // Drive the RAM side straight from the decode and the pointer.
    always_comb begin
        ram_addr  = BASE | ADDR_W'(ptr);
        ram_wdata = cpu_wdata;
        ram_rd    = data_rd;
        ram_wr    = data_wr;
    end
endmodule

// File: rtl/wram_port_chk.sv
// Checker for the work-RAM access port; it observes the ports only.
module wram_port_chk #(
    parameter int                PTR_W  = 17,
    parameter int                ADDR_W = 24,
    parameter int                DW     = 8,
    parameter logic [ADDR_W-1:0] BASE   = 24'h7E0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_sel,
    input logic [1:0]        cpu_reg,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [DW-1:0]     cpu_wdata,
    input logic [DW-1:0]     cpu_rdata,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_rd,
    input logic              ram_wr
);
    localparam int TOP_LO = ((PTR_W - 1) / DW) * DW;

    logic             acc, acc_q, ld_now, hi_ld, ob_rd;
    logic [PTR_W-1:0] last_ptr;

    // Mirror of the access and load conditions, built from the ports.
    always_comb begin
        acc    = cpu_sel && cpu_reg == 2'd0 && (cpu_rd || cpu_wr);
        ld_now = cpu_sel && cpu_wr && cpu_reg != 2'd0;
        hi_ld  = cpu_sel && cpu_wr && cpu_reg == 2'd3;
        ob_rd  = cpu_sel && cpu_rd && !cpu_wr && cpu_reg != 2'd0;
    end

    // Track the access in progress and the pointer it used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= 1'b0;
            last_ptr <= '0;
        end else begin
            acc_q <= acc;
            if (acc) last_ptr <= ram_addr[PTR_W-1:0];
        end
    end

    a_r1_reset_ptr: assert property (@(posedge clk)
        !rst_n |=> (ram_addr[PTR_W-1:0] == '0 && !ram_rd && !ram_wr));

    a_r2_base_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ram_addr[ADDR_W-1:PTR_W] == BASE[ADDR_W-1:PTR_W]);

    // Covers R3, R4 and R5: the step is taken modulo 2^PTR_W.
    a_r5_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q && !acc && !ld_now) |=> ram_addr[PTR_W-1:0] == PTR_W'(last_ptr + 1'b1));

    a_r6_hi_lane_only: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_ld && !acc_q) |=> (ram_addr[TOP_LO-1:0] == $past(ram_addr[TOP_LO-1:0])
            && ram_addr[PTR_W-1:TOP_LO] == $past(cpu_wdata[PTR_W-TOP_LO-1:0])));

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (acc -> $stable(ram_addr)));

    a_r8_open_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_wr) |=> (ob_rd -> cpu_rdata == $past(cpu_wdata)));

    a_r9_strobe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_sel && cpu_reg == 2'd0) |-> (!ram_rd && !ram_wr));

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_rd && ram_wr));
endmodule

bind wram_port wram_port_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .DW(DW), .BASE(BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_sel   (cpu_sel),
    .cpu_reg   (cpu_reg),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .ram_addr  (ram_addr),
    .ram_rd    (ram_rd),
    .ram_wr    (ram_wr)
);

// File: tb/wram_port_test.sv
// Scoreboard bench for the work-RAM access port.
module wram_port_test;
    localparam logic [23:0] BASE = 24'h7E0000;
    localparam int K_WR = 0, K_RD = 1, K_OB = 2, K_LD = 3;

    typedef struct {
        int          kind;
        logic [23:0] addr;
        logic [7:0]  data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [1:0]  cpu_reg = 2'd0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata, ram_wdata, ram_rdata;
    logic [23:0] ram_addr;
    logic        ram_rd, ram_wr;

    logic [7:0]  mem    [4096];
    logic [7:0]  shadow [4096];
    exp_t        q[$];
    logic [16:0] mptr = '0;
    logic [7:0]  mbus = 8'h00;
    int          checks = 0, fails = 0;
    logic        prev_act = 1'b0;
    logic [23:0] held_addr = '0;

    always #2 clk = ~clk;

    wram_port uut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_reg(cpu_reg),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .ram_rd(ram_rd), .ram_wr(ram_wr)
    );

    // RAM model: asynchronous read, write on the clock edge.
    assign ram_rdata = mem[ram_addr[11:0]];
    always @(posedge clk) if (ram_wr) mem[ram_addr[11:0]] <= ram_wdata;

    task automatic report(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Monitor: compare the first cycle of each window access with the queue head.
    always @(negedge clk) begin
        logic act;
        act = rst_n && cpu_sel && (cpu_rd || cpu_wr);
        if (act && prev_act && cpu_reg == 2'd0)
            report(ram_addr == held_addr, "R7",
                   $sformatf("held addr act=%h exp=%h", ram_addr, held_addr));
        if (act && !prev_act) begin
            held_addr = ram_addr;
            if (q.size() == 0) begin
                report(1'b0, "R9", "access with no expected item");
            end else begin
                exp_t e;
                bit   ok;
                e = q.pop_front();
                case (e.kind)
                    K_WR: ok = ram_wr && !ram_rd && ram_addr == e.addr && ram_wdata == e.data;
                    K_RD: ok = ram_rd && !ram_wr && ram_addr == e.addr && cpu_rdata == e.data;
                    K_OB: ok = !ram_rd && !ram_wr && cpu_rdata == e.data;
                    default: ok = !ram_rd && !ram_wr;
                endcase
                report(ok, e.tag, $sformatf(
                    "kind=%0d act addr=%h wdata=%h rdata=%h rd=%b wr=%b exp addr=%h data=%h",
                    e.kind, ram_addr, ram_wdata, cpu_rdata, ram_rd, ram_wr, e.addr, e.data));
            end
        end
        prev_act = act;
    end

    // Driver primitive: hold one processor cycle for 'hold' clocks, then release.
    task automatic access(input logic sel, input logic [1:0] r, input logic rd,
                          input logic wr, input logic [7:0] d, input int hold);
        @(posedge clk); #1;
        cpu_sel = sel; cpu_reg = r; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
        repeat (hold) @(posedge clk);
        #1;
        cpu_sel = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] d, input string tag, input int hold = 1,
                           input logic also_rd = 1'b0);
        q.push_back('{K_WR, BASE | 24'(mptr), d, tag});
        shadow[mptr[11:0]] = d;
        mbus = d;
        access(1'b1, 2'd0, also_rd, 1'b1, d, hold);
        mptr = mptr + 17'd1;
    endtask

    task automatic rd_data(input string tag, input int hold = 1);
        q.push_back('{K_RD, BASE | 24'(mptr), shadow[mptr[11:0]], tag});
        mbus = shadow[mptr[11:0]];
        access(1'b1, 2'd0, 1'b1, 1'b0, 8'h00, hold);
        mptr = mptr + 17'd1;
    endtask

    task automatic ld(input logic [1:0] r, input logic [7:0] d, input string tag);
        q.push_back('{K_LD, 24'h0, d, tag});
        case (r)
            2'd1: mptr[7:0]  = d;
            2'd2: mptr[15:8] = d;
            default: mptr[16] = d[0];
        endcase
        mbus = d;
        access(1'b1, r, 1'b0, 1'b1, d, 1);
    endtask

    task automatic rd_ob(input logic [1:0] r, input string tag);
        q.push_back('{K_OB, 24'h0, mbus, tag});
        access(1'b1, r, 1'b1, 1'b0, 8'h00, 1);
    endtask

    initial begin
        #(4 * 20000);
        report(1'b0, "watchdog", "run did not finish in time");
        finish_run();
    end

    initial begin
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        report(ram_addr == BASE && !ram_rd && !ram_wr, "R1",
               $sformatf("addr=%h rd=%b wr=%b exp %h 0 0", ram_addr, ram_rd, ram_wr, BASE));
        @(posedge clk); #1 rst_n = 1'b1;

        rd_ob(2'd1, "R1");                  // open-bus byte starts at 0x00
        wr_data(8'h11, "R3");
        wr_data(8'h22, "R3");
        ld(2'd1, 8'h00, "R6");
        rd_data("R4");
        rd_data("R4");
        rd_ob(2'd2, "R8");                  // last data read (0x22)

        ld(2'd1, 8'h34, "R6");
        ld(2'd2, 8'h12, "R6");
        ld(2'd3, 8'h01, "R6");
        wr_data(8'hA5, "R2");               // 0x7F1234
        ld(2'd3, 8'hFE, "R6");              // bit 16 cleared, bits 15:0 kept
        wr_data(8'h5A, "R6");               // 0x7E1235
        ld(2'd2, 8'hAB, "R6");
        wr_data(8'h77, "R6");               // 0x7EAB36
        rd_ob(2'd3, "R8");                  // last write (0x77)

        ld(2'd1, 8'hFF, "R5");
        ld(2'd2, 8'hFF, "R5");
        ld(2'd3, 8'h03, "R5");              // only bit 0 taken
        wr_data(8'hC3, "R5");               // 0x7FFFFF
        wr_data(8'h3C, "R5");               // wraps to 0x7E0000
        ld(2'd1, 8'hFF, "R5");
        ld(2'd2, 8'hFF, "R5");
        ld(2'd3, 8'h01, "R5");
        rd_data("R5");
        rd_data("R5");                      // read wrap

        ld(2'd1, 8'h40, "R7");
        ld(2'd2, 8'h00, "R7");
        ld(2'd3, 8'h00, "R7");
        wr_data(8'h9E, "R7", 4);
        wr_data(8'h9F, "R7");
        ld(2'd1, 8'h40, "R7");
        rd_data("R7", 3);
        rd_data("R7");

        // R9: deselected data write raises no strobe and keeps the pointer.
        @(posedge clk); #1;
        cpu_sel = 1'b0; cpu_reg = 2'd0; cpu_wr = 1'b1; cpu_wdata = 8'hEE;
        @(negedge clk);
        report(!ram_wr && !ram_rd, "R9",
               $sformatf("rd=%b wr=%b exp 0 0", ram_rd, ram_wr));
        @(posedge clk); #1 cpu_wr = 1'b0;
        wr_data(8'h61, "R9");               // still at 0x00042
        wr_data(8'h62, "R9", 1, 1'b1);      // read and write together act as a write
        ld(2'd1, 8'h43, "R9");
        rd_data("R9");

        repeat (3) @(posedge clk);
        report(q.size() == 0, "R9", $sformatf("queue left %0d exp 0", q.size()));
        finish_run();
    end
endmodule